// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's complement operands of width N and returns a signed product of width 2N. It examines one recoded bit pair per clock cycle and needs no multiplier array. A single 2N-bit working register holds the multiplier in its low half at the start. Each cycle, the upper half is either left alone or has the multiplicand added to it or subtracted from it. The register is then shifted right arithmetically by one place. The bit that drops off the bottom is kept in a one-bit history flop, which pairs with the next low bit.

A caller waits for `busy_o` to be low and then presents the operands with a one-cycle `start_i`. It picks up the result when `done_o` pulses. The product output shows the working register at all times. It is final from the `done_o` cycle onward and stays put until the next accepted start.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is held and directly after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A `start_i` sampled high while `busy_o` is low is accepted: the operands are captured and `busy_o` is 1 in the following cycle.
- R3: On completion, `product_o` equals the signed product of the captured operands, truncated to 2N bits, for every combination of operand signs.
- R4: The product is correct when either or both operands are the most negative N-bit value, including the case where subtracting the multiplicand overflows N bits.
- R5: `busy_o` stays high for exactly N cycles after an accepted start. `done_o` is high for exactly one cycle, namely the cycle after the last busy cycle, and `busy_o` is low in that cycle.
- R6: A `start_i` that arrives while `busy_o` is high has no effect: the running result, its timing and the count of results stay unchanged.
- R7: After `done_o`, `product_o` keeps its value until the next accepted start.
- R8: A `start_i` in the same cycle as `done_o` is accepted, so operations can run back to back with no idle cycle.
- R9: During an operation, `product_o` shows the working register after each shift. For N=4, multiplicand 0010 and multiplier 1101 give the successive values 0000_1101 (loaded), 1111_0110, 0000_1011, 1111_0101 and 1111_1010, the last being -6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, honoured only when not busy |
| mcand_i | input | N | Signed multiplicand |
| mplier_i | input | N | Signed multiplier |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: product is final |
| product_o | output | 2N | Signed product (working register) |

## Verification
The completion pulse of one operation and the acceptance of the next start can fall in the same cycle. This is because `busy_o` has already fallen when `done_o` is high. The bench provokes it by raising `start_i` in the very cycle it sees `done_o`. It then judges that the monitor still retires the first product against the scoreboard, that `busy_o` is high one cycle later, and that the second product arrives after exactly N more busy cycles. A start raised in the middle of a run is also driven, with different operands, and the bench checks that it leaves both the result and the number of queued results unchanged.

// File: rtl/booth_pkg.sv
// Package: shared types for the Booth multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package booth_pkg;
    typedef enum logic [1:0] {
        BOP_HOLD = 2'd0,
        BOP_ADD  = 2'd1,
        BOP_SUB  = 2'd2
    } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
// Module: booth_recode
// Maps the current low bit and the history bit onto a Booth action.
// Assumes the history bit is 0 before the first step (implicit bit -1).
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_bit_i,
    input  logic      hist_bit_i,
    output booth_op_e op_o
);
    // Decode the (current, previous) pair into hold, add or subtract.
    always_comb begin
        unique case ({cur_bit_i, hist_bit_i})
            2'b10:   op_o = BOP_SUB;
            2'b01:   op_o = BOP_ADD;
            default: op_o = BOP_HOLD;
        endcase
    end
endmodule

// File: rtl/booth_step.sv
// Module: booth_step
// One combined iteration: add/subtract on the upper half, then an
// arithmetic right shift by one. The sum is formed one bit wider than
// the half so that the sign shifted in is the true sign even when the
// N-bit result overflows (e.g. subtracting the most negative value).
// Assumes the working register holds a valid partial product.
module booth_step
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [2*N-1:0] p_i,
    input  logic [N-1:0]   m_i,
    input  booth_op_e      op_i,
    output logic [2*N-1:0] p_next_o
);
    localparam int W = N + 1;

    logic [W-1:0] hi_ext;
    logic [W-1:0] m_ext;
    logic [W-1:0] sum;

    // Sign-extend both operands to the widened adder width.
    always_comb begin
        hi_ext = {p_i[2*N-1], p_i[2*N-1:N]};
        m_ext  = {m_i[N-1], m_i};
    end

    // Widened add, subtract or pass-through of the upper half.
    always_comb begin
        unique case (op_i)
            BOP_ADD: sum = hi_ext + m_ext;
            BOP_SUB: sum = hi_ext - m_ext;
            default: sum = hi_ext;
        endcase
    end

    // Arithmetic shift right by one using the true sign bit of the sum.
    always_comb begin
        p_next_o = {sum[W-1], sum[N-1:0], p_i[N-1:1]};
    end
endmodule

// File: rtl/booth_ctrl.sv
// Module: booth_ctrl
// Sequencer: accepts a start when idle, runs exactly N step cycles,
// then pulses done for one cycle. Starts during a run are dropped.
// Assumes start is synchronous to clk.
module booth_ctrl #(
    parameter int N = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic          busy_q;
    logic          done_q;
    logic [CW-1:0] iter_q;

    // Accept a start only while idle.
    always_comb begin
        load_o = start_i && !busy_q;
        step_o = busy_q;
        busy_o = busy_q;
        done_o = done_q;
    end

    // Busy flag, iteration counter and one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            iter_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q <= 1'b1;
                iter_q <= '0;
            end else if (busy_q) begin
                if (iter_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    iter_q <= iter_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/booth_seq_mul.sv
// Module: booth_seq_mul (top)
// Iterative radix-2 Booth multiplier for signed N-bit operands giving a
// 2N-bit signed product. Holds multiplicand, the shared product register
// and the one-bit history; one recoded pair is consumed per cycle.
// Assumes N >= 2 and operands stable only in the start cycle.
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*N-1:0] product_o
);
    localparam int PW = 2 * N;

    logic [N-1:0]  m_q;
    logic [PW-1:0] p_q;
    logic          hist_q;
    logic [PW-1:0] p_next;
    booth_op_e     op;
    logic          load;
    logic          step;

    booth_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    booth_recode u_rec (
        .cur_bit_i  (p_q[0]),
        .hist_bit_i (hist_q),
        .op_o       (op)
    );

    booth_step #(.N(N)) u_step (
        .p_i      (p_q),
        .m_i      (m_q),
        .op_i     (op),
        .p_next_o (p_next)
    );

    // Load operands on accept, otherwise advance one step while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q    <= '0;
            p_q    <= '0;
            hist_q <= 1'b0;
        end else if (load) begin
            m_q    <= mcand_i;
            p_q    <= {{N{1'b0}}, mplier_i};
            hist_q <= 1'b0;
        end else if (step) begin
            p_q    <= p_next;
            hist_q <= p_q[0];
        end
    end

    // The product output is the working register itself.
    always_comb product_o = p_q;
endmodule

// File: rtl/booth_seq_mul_chk.sv
// Module: booth_seq_mul_chk
// Property checker bound to booth_seq_mul. Keeps a shadow of accepted
// operands and a cycle counter to judge timing and the final product.
// Assumes the same parameter N as the checked instance.
module booth_seq_mul_chk #(
    parameter int N = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [N-1:0]   mcand_i,
    input logic [N-1:0]   mplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*N-1:0] product_o
);
    logic [N-1:0]   sa_q;
    logic [N-1:0]   sb_q;
    int unsigned    cyc_q;
    logic [2*N-1:0] ref_prod;

    // Shadow accepted operands and count busy cycles since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_q  <= '0;
            sb_q  <= '0;
            cyc_q <= 0;
        end else if (start_i && !busy_o) begin
            sa_q  <= mcand_i;
            sb_q  <= mplier_i;
            cyc_q <= 0;
        end else if (busy_o) begin
            cyc_q <= cyc_q + 1;
        end
    end

    // Reference signed product of the shadowed operands.
    always_comb begin
        ref_prod = {{N{sa_q[N-1]}}, sa_q} * {{N{sb_q[N-1]}}, sb_q};
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && product_o == '0));

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r3_r4_product: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> product_o == ref_prod);

    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cyc_q == N);

    a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !$past(done_o)));

    a_r6_busy_start_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && cyc_q < N - 1) |=> (busy_o && !done_o));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/sim_booth_seq_mul.sv
// Scoreboard bench for booth_seq_mul (N=32 as u0, N=4 as u1 for traces).
module sim_booth_seq_mul;
    localparam int N = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   a = '0;
    logic [N-1:0]   b = '0;
    logic           busy, done;
    logic [2*N-1:0] prod;

    logic       start1 = 1'b0;
    logic [3:0] a1 = '0, b1 = '0;
    logic       busy1, done1;
    logic [7:0] prod1;

    int errors = 0;
    int checks = 0;
    logic [2*N-1:0] sb_q[$];
    string          sb_tag[$];

    always #2 clk = ~clk;

    booth_seq_mul #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mcand_i(a), .mplier_i(b),
        .busy_o(busy), .done_o(done), .product_o(prod));

    booth_seq_mul #(.N(4)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start1), .mcand_i(a1), .mplier_i(b1),
        .busy_o(busy1), .done_o(done1), .product_o(prod1));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] sprod(input logic [N-1:0] x, input logic [N-1:0] y);
        logic signed [2*N-1:0] xs, ys;
        xs = $signed(x);
        ys = $signed(y);
        return xs * ys;
    endfunction

    // Driver: wait for idle, issue one start, push expected product.
    task automatic issue(input logic [N-1:0] x, input logic [N-1:0] y, input string req);
        while (busy) @(negedge clk);
        a = x; b = y; start = 1'b1;
        sb_q.push_back(sprod(x, y));
        sb_tag.push_back(req);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for the scoreboard to drain.
    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: pop and compare on each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                chk("R6 unexpected result", 64'd1, 64'd0);
            end else begin
                chk(sb_tag.pop_front(), prod, sb_q.pop_front());
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cnt;
        logic [2*N-1:0] held;
        repeat (3) @(negedge clk);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 product", prod, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 64'({busy, done}), 64'd0);

        // R9: N=4 trace 0010 x 1101
        a1 = 4'b0010; b1 = 4'b1101; start1 = 1'b1;
        @(negedge clk); start1 = 1'b0;
        chk("R9 load", 64'(prod1), 64'h0D);
        chk("R2 busy after accept", 64'(busy1), 64'd1);
        @(negedge clk); chk("R9 step1", 64'(prod1), 64'hF6);
        @(negedge clk); chk("R9 step2", 64'(prod1), 64'h0B);
        @(negedge clk); chk("R9 step3", 64'(prod1), 64'hF5);
        @(negedge clk); chk("R9 step4", 64'(prod1), 64'hFA);
        chk("R9 done", 64'(done1), 64'd1);

        // R3: sign mixes and the known long example
        issue(32'd6, 32'd2, "R3 pos*pos");
        issue(-32'sd100, 32'd99, "R3 neg*pos");
        issue(32'd2, -32'sd3, "R3 pos*neg");
        issue(-32'sd5, -32'sd3, "R3 neg*neg");
        issue(32'd0, 32'h1234_5678, "R3 zero");
        for (int i = 0; i < 20; i++) issue($urandom, $urandom, "R3 mixed");
        drain();

        // R4: most negative value corners
        issue(32'h8000_0000, 32'h8000_0000, "R4 min*min");
        issue(32'h8000_0000, 32'hFFFF_FFFF, "R4 min*-1");
        issue(32'h8000_0000, 32'd1, "R4 min*1");
        issue(32'h7FFF_FFFF, 32'h8000_0000, "R4 max*min");
        drain();

        // R5: done after N+1 negedges, single pulse
        @(negedge clk);
        a = 32'd7; b = 32'd9; start = 1'b1;
        sb_q.push_back(sprod(32'd7, 32'd9)); sb_tag.push_back("R5 value");
        cnt = 0;
        @(negedge clk); start = 1'b0; cnt++;
        while (!done && cnt < 200) begin @(negedge clk); cnt++; end
        chk("R5 latency", 64'(cnt), 64'(N + 1));
        chk("R5 busy low at done", 64'(busy), 64'd0);
        held = prod;
        @(negedge clk);
        chk("R5 done one cycle", 64'(done), 64'd0);

        // R7: product held while idle
        repeat (5) @(negedge clk);
        chk("R7 hold", prod, held);

        // R6: start while busy dropped
        issue(32'd11, 32'd13, "R6 first kept");
        repeat (4) @(negedge clk);
        a = 32'd99; b = 32'd99; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R6 still busy", 64'(busy), 64'd1);
        drain();
        repeat (N + 4) @(negedge clk);
        chk("R6 no extra result", 64'(sb_q.size()), 64'd0);
        chk("R6 idle", 64'(busy), 64'd0);

        // R8: start in the done cycle
        issue(-32'sd7, 32'd6, "R8 first");
        while (!done) @(negedge clk);
        a = 32'd123; b = -32'sd45; start = 1'b1;
        sb_q.push_back(sprod(32'd123, -32'sd45)); sb_tag.push_back("R8 second");
        @(negedge clk); start = 1'b0;
        chk("R8 busy after done-cycle start", 64'(busy), 64'd1);
        cnt = 1;
        while (!done && cnt < 200) begin @(negedge clk); cnt++; end
        chk("R8 second latency", 64'(cnt), 64'(N + 1));
        drain();

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule